// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt and Wake Unit

This unit watches a wide port of already-synchronized GPIO inputs, organised as banks of 32 pins. Software picks, per pin, edge-sensitive detection (rising, falling or both) or level-sensitive detection with a chosen active polarity. Every detected event latches into an interrupt status bit and, in parallel, into a wake status bit. Both status words are cleared by writing ones.

An interrupt enable word gates the interrupt status bits. All enabled pending bits across every bank are merged into one interrupt line, which feeds a higher-level interrupt controller. A wake enable word gates the wake status bits in the same way, and their OR drives a single wake request.

A simple register port is used for configuration and status access. Writes take one clock. Read data is combinational from the address.

Top module: `gpio_iw_unit`

## Requirements
- R1: After reset, every configuration and status word reads 0, and `irq` and `wake_req` are low.
- R2: Each register kind has its own base address: rising enable 0x064, falling enable 0x07c, interrupt enable 0x0ac, interrupt status 0x0c4, input type 0x300, level polarity 0x318, wake enable 0x400, wake status 0x418. The word for pin n is at base + 4*(n/32), bit n%32. Configuration words read back what was written. An address that is outside these ranges, or that has its two low bits nonzero, reads 0 and ignores writes.
- R3: When the input type bit is 0 (edge mode), a 0-to-1 change of a pin with its rising enable set, or a 1-to-0 change with its falling enable set, sets the pin's interrupt status bit at the clock edge where the new level is first sampled. Both enables may be set together.
- R4: When the input type bit is 1 (level mode), the pin's status bit is set on every clock where the pin is active. With polarity 0 the active level is high; with polarity 1 it is low. Clearing the bit while the level is still active has no lasting effect.
- R5: Writing 1 to an interrupt status bit clears it. Writing 0 leaves it unchanged. A set bit stays set until it is cleared.
- R6: If a new event and a clear of the same status bit fall on the same clock, the bit ends up set.
- R7: `irq` is high exactly when some bank has a status bit set whose interrupt enable bit is 1.
- R8: The wake status bit of a pin is set by the same event as its interrupt status bit, and it is cleared by writing 1. `wake_req` is high exactly when a wake status bit is set whose wake enable bit is 1.
- R9: A configuration write takes effect from the clock after the write. Changing polarity or input type creates no status bit on the write's own clock.
- R10: An edge whose enable is 0 sets no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | NUM_BANKS*32 | Synchronized GPIO pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Combined wake request |

## Verification
The bench builds the unit with its defaults: six banks (192 pins) and a 12-bit address. With these values the top pin 191 and the last word of every register range can be reached, so the bank-boundary decode and the gap addresses between ranges are exercised. Directed cases cover an event colliding with a clear, a polarity flip in level mode, and disabled edges. A long random phase, with pins, configuration and clears all changing together, is compared against a reference model kept in the bench.

// File: rtl/gpio_iw_pkg.sv
package gpio_iw_pkg;

    localparam int BANK_W = 32;
    localparam int KIND_N = 8;

    typedef enum logic [3:0] {
        K_RISE  = 4'd0,
        K_FALL  = 4'd1,
        K_MASK  = 4'd2,
        K_STAT  = 4'd3,
        K_TYPE  = 4'd4,
        K_POL   = 4'd5,
        K_WMASK = 4'd6,
        K_WSTAT = 4'd7,
        K_NONE  = 4'd15
    } reg_kind_e;

    typedef struct packed {
        logic [BANK_W-1:0] rise;
        logic [BANK_W-1:0] fall;
        logic [BANK_W-1:0] ien;
        logic [BANK_W-1:0] lvl;
        logic [BANK_W-1:0] low;
        logic [BANK_W-1:0] wen;
    } bank_cfg_t;

    typedef struct packed {
        logic [BANK_W-1:0] irq_st;
        logic [BANK_W-1:0] wake_st;
    } bank_stat_t;

    function automatic int kind_base(input int k);
        case (k)
            0:       return 'h064;
            1:       return 'h07c;
            2:       return 'h0ac;
            3:       return 'h0c4;
            4:       return 'h300;
            5:       return 'h318;
            6:       return 'h400;
            default: return 'h418;
        endcase
    endfunction

endpackage

// File: rtl/gpio_iw_decode.sv
module gpio_iw_decode
    import gpio_iw_pkg::*;
#(
    parameter int NUM_BANKS = 6,
    parameter int ADDR_W    = 12,
    localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [BIDX_W-1:0] bank
);

    int a_int;

    always_comb begin
        kind  = K_NONE;
        bank  = '0;
        a_int = int'(addr);
        for (int k = 0; k < KIND_N; k++) begin
            if (addr[1:0] == 2'b00 &&
                a_int >= kind_base(k) &&
                a_int < kind_base(k) + 4 * NUM_BANKS) begin
                kind = reg_kind_e'(4'(k));
                bank = BIDX_W'((a_int - kind_base(k)) / 4);
            end
        end
    end

endmodule

// File: rtl/gpio_iw_detect.sv
module gpio_iw_detect
    import gpio_iw_pkg::*;
(
    input  logic [BANK_W-1:0] pin_now,
    input  logic [BANK_W-1:0] pin_prev,
    input  bank_cfg_t         cfg,
    output logic [BANK_W-1:0] evt
);

    logic [BANK_W-1:0] up_edge;
    logic [BANK_W-1:0] down_edge;
    logic [BANK_W-1:0] edge_hit;
    logic [BANK_W-1:0] level_hit;

    always_comb begin
        up_edge   = pin_now & ~pin_prev;
        down_edge = ~pin_now & pin_prev;
        edge_hit  = (up_edge & cfg.rise) | (down_edge & cfg.fall);
        level_hit = pin_now ^ cfg.low;
        evt       = (cfg.lvl & level_hit) | (~cfg.lvl & edge_hit);
    end

endmodule

// File: rtl/gpio_iw_bank.sv
module gpio_iw_bank
    import gpio_iw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] pins,
    input  logic              wr_en,
    input  reg_kind_e         wr_kind,
    input  logic [BANK_W-1:0] wdata,
    output bank_cfg_t         cfg,
    output bank_stat_t        stat,
    output logic [BANK_W-1:0] evt,
    output logic [BANK_W-1:0] clr_irq,
    output logic [BANK_W-1:0] clr_wake
);

    logic [BANK_W-1:0] prev_q;

    gpio_iw_detect u_detect (
        .pin_now  (pins),
        .pin_prev (prev_q),
        .cfg      (cfg),
        .evt      (evt)
    );

    always_comb begin
        clr_irq  = (wr_en && wr_kind == K_STAT)  ? wdata : '0;
        clr_wake = (wr_en && wr_kind == K_WSTAT) ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            cfg    <= '0;
            stat   <= '0;
        end else begin
            prev_q       <= pins;
            stat.irq_st  <= (stat.irq_st & ~clr_irq) | evt;
            stat.wake_st <= (stat.wake_st & ~clr_wake) | evt;
            if (wr_en) begin
                case (wr_kind)
                    K_RISE:  cfg.rise <= wdata;
                    K_FALL:  cfg.fall <= wdata;
                    K_MASK:  cfg.ien  <= wdata;
                    K_TYPE:  cfg.lvl  <= wdata;
                    K_POL:   cfg.low  <= wdata;
                    K_WMASK: cfg.wen  <= wdata;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_iw_unit.sv
module gpio_iw_unit
    import gpio_iw_pkg::*;
#(
    parameter int NUM_BANKS = 6,
    parameter int ADDR_W    = 12,
    localparam int PINS_W   = NUM_BANKS * BANK_W,
    localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS_W-1:0] pins_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    output logic [BANK_W-1:0] reg_rdata,
    output logic              irq,
    output logic              wake_req
);

    reg_kind_e         dec_kind;
    logic [BIDX_W-1:0] dec_bank;

    bank_cfg_t  cfg_q  [NUM_BANKS];
    bank_stat_t stat_q [NUM_BANKS];

    logic [PINS_W-1:0] stat_all;
    logic [PINS_W-1:0] wstat_all;
    logic [PINS_W-1:0] ien_all;
    logic [PINS_W-1:0] wen_all;
    logic [PINS_W-1:0] evt_all;
    logic [PINS_W-1:0] clr_all;
    logic [PINS_W-1:0] wclr_all;

    gpio_iw_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr (reg_addr),
        .kind (dec_kind),
        .bank (dec_bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = reg_we && (dec_kind != K_NONE) &&
                         (int'(dec_bank) == b);

        gpio_iw_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .pins     (pins_in[b*BANK_W +: BANK_W]),
            .wr_en    (bank_wr),
            .wr_kind  (dec_kind),
            .wdata    (reg_wdata),
            .cfg      (cfg_q[b]),
            .stat     (stat_q[b]),
            .evt      (evt_all[b*BANK_W +: BANK_W]),
            .clr_irq  (clr_all[b*BANK_W +: BANK_W]),
            .clr_wake (wclr_all[b*BANK_W +: BANK_W])
        );

        assign stat_all[b*BANK_W +: BANK_W]  = stat_q[b].irq_st;
        assign wstat_all[b*BANK_W +: BANK_W] = stat_q[b].wake_st;
        assign ien_all[b*BANK_W +: BANK_W]   = cfg_q[b].ien;
        assign wen_all[b*BANK_W +: BANK_W]   = cfg_q[b].wen;
    end

    always_comb begin
        reg_rdata = '0;
        case (dec_kind)
            K_RISE:  reg_rdata = cfg_q[dec_bank].rise;
            K_FALL:  reg_rdata = cfg_q[dec_bank].fall;
            K_MASK:  reg_rdata = cfg_q[dec_bank].ien;
            K_STAT:  reg_rdata = stat_q[dec_bank].irq_st;
            K_TYPE:  reg_rdata = cfg_q[dec_bank].lvl;
            K_POL:   reg_rdata = cfg_q[dec_bank].low;
            K_WMASK: reg_rdata = cfg_q[dec_bank].wen;
            K_WSTAT: reg_rdata = stat_q[dec_bank].wake_st;
            default: reg_rdata = '0;
        endcase
    end

    assign irq      = |(stat_all & ien_all);
    assign wake_req = |(wstat_all & wen_all);

endmodule

// File: rtl/gpio_iw_checker.sv
module gpio_iw_checker #(
    parameter int NUM_BANKS = 6,
    localparam int PINS_W   = NUM_BANKS * 32
) (
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              wake_req,
    input logic [PINS_W-1:0] stat_all,
    input logic [PINS_W-1:0] wstat_all,
    input logic [PINS_W-1:0] evt_all,
    input logic [PINS_W-1:0] clr_all
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq && !wake_req)); // R1

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_all) & ~$past(clr_all) & ~stat_all) == '0)); // R5

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_all & $past(clr_all) & ~$past(evt_all)) == '0)); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(evt_all) & ~stat_all) == '0)); // R6

    AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(evt_all) & ~wstat_all) == '0)); // R8

    AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (rst)
        (stat_all == '0) |-> !irq); // R7

endmodule

bind gpio_iw_unit gpio_iw_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .wake_req  (wake_req),
    .stat_all  (stat_all),
    .wstat_all (wstat_all),
    .evt_all   (evt_all),
    .clr_all   (clr_all)
);

// File: tb/tb_gpio_iw_unit.sv
module tb_gpio_iw_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 6;
    localparam int PW         = NB * 32;
    localparam int RAND_CYC   = 4000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] pins = '0;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;
    logic          wake_req;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_iw_unit #(.NUM_BANKS(NB), .ADDR_W(12)) dut (
        .clk       (clk),
        .rst       (rst),
        .pins_in   (pins),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .wake_req  (wake_req)
    );

    // reference model: [kind][bank], kinds 0..7 in base order of R2
    logic [31:0]   m_reg [8][NB];
    logic [PW-1:0] m_prev;

    function automatic int base_of(input int k);
        int tbl [8] = '{'h064, 'h07c, 'h0ac, 'h0c4, 'h300, 'h318, 'h400, 'h418};
        return tbl[k];
    endfunction

    function automatic int addr_kind(input logic [11:0] a);
        for (int k = 0; k < 8; k++)
            if (a[1:0] == 0 && int'(a) >= base_of(k) && int'(a) < base_of(k) + 4*NB)
                return k;
        return -1;
    endfunction

    function automatic int addr_bank(input logic [11:0] a, input int k);
        return (int'(a) - base_of(k)) / 4;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 8; k++)
            for (int b = 0; b < NB; b++) m_reg[k][b] = '0;
        m_prev = '0;
    endtask

    task automatic model_step(input logic [PW-1:0] p, input logic we,
                              input logic [11:0] a, input logic [31:0] d);
        int k;
        int bk;
        k  = addr_kind(a);
        bk = (k >= 0) ? addr_bank(a, k) : 0;
        for (int b = 0; b < NB; b++) begin
            logic [31:0] now, old, ev, clr, wclr;
            now = p[b*32 +: 32];
            old = m_prev[b*32 +: 32];
            for (int i = 0; i < 32; i++) begin
                if (m_reg[4][b][i])
                    ev[i] = now[i] != m_reg[5][b][i];
                else
                    ev[i] = (now[i] && !old[i] && m_reg[0][b][i]) ||
                            (!now[i] && old[i] && m_reg[1][b][i]);
            end
            clr  = (we && k == 3 && bk == b) ? d : 32'h0;
            wclr = (we && k == 7 && bk == b) ? d : 32'h0;
            m_reg[3][b] = (m_reg[3][b] & ~clr) | ev;
            m_reg[7][b] = (m_reg[7][b] & ~wclr) | ev;
            if (we && k >= 0 && k != 3 && k != 7 && bk == b) m_reg[k][b] = d;
        end
        m_prev = p;
    endtask

    function automatic logic exp_irq();
        logic r = 0;
        for (int b = 0; b < NB; b++) r |= |(m_reg[3][b] & m_reg[2][b]);
        return r;
    endfunction

    function automatic logic exp_wake();
        logic r = 0;
        for (int b = 0; b < NB; b++) r |= |(m_reg[7][b] & m_reg[6][b]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    localparam logic [31:0] B5  = 32'h0000_0020;
    localparam logic [31:0] B31 = 32'h8000_0000;

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk); tick(); tick();
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 wake_req", {31'b0, wake_req}, 0);
        for (int k = 0; k < 8; k++) begin
            rd(12'(base_of(k)), v);
            chk("R1 reg reset", v, 0);
        end

        // R2 map, read back, bank boundary, unmapped and misaligned
        wr(12'h078, 32'hA5A5_5A5A);
        rd(12'h078, v); chk("R2 readback top rise word", v, 32'hA5A5_5A5A);
        rd(12'h064, v); chk("R2 other bank untouched", v, 0);
        wr(12'h200, 32'hFFFF_FFFF);
        rd(12'h200, v); chk("R2 unmapped reads 0", v, 0);
        rd(12'h079, v); chk("R2 misaligned reads 0", v, 0);
        wr(12'h078, 32'h0);

        // R3 rising edge on pin 37 (bank 1 bit 5)
        wr(12'h068, B5);
        wr(12'h0b0, B5);
        chk("R7 no event no irq", {31'b0, irq}, 0);
        pins[37] = 1'b1; tick();
        chk("R3 rising sets irq", {31'b0, irq}, 1);
        rd(12'h0c8, v); chk("R3 status bit", v, B5);
        wr(12'h0c8, 32'h0);
        rd(12'h0c8, v); chk("R5 write 0 keeps", v, B5);
        wr(12'h0c8, B5);
        rd(12'h0c8, v); chk("R5 write 1 clears", v, 0);
        chk("R5 irq drops", {31'b0, irq}, 0);

        // R10 falling edge with falling enable off
        pins[37] = 1'b0; tick();
        rd(12'h0c8, v); chk("R10 disabled edge ignored", v, 0);
        wr(12'h080, B5);
        pins[37] = 1'b1; tick();
        wr(12'h0c8, B5);
        pins[37] = 1'b0; tick();
        rd(12'h0c8, v); chk("R3 falling edge sets", v, B5);

        // R8 wake path
        rd(12'h41c, v); chk("R8 wake status set", v, B5);
        chk("R8 wake masked", {31'b0, wake_req}, 0);
        wr(12'h404, B5);
        chk("R8 wake_req high", {31'b0, wake_req}, 1);
        wr(12'h41c, B5);
        rd(12'h41c, v); chk("R8 wake clear", v, 0);
        chk("R8 wake_req low", {31'b0, wake_req}, 0);

        // R7 enable gates irq
        wr(12'h0b0, 32'h0);
        chk("R7 disabled irq low", {31'b0, irq}, 0);
        rd(12'h0c8, v); chk("R7 status kept", v, B5);
        wr(12'h0c8, B5);

        // R6 event and clear on the same clock
        pins[37] = 1'b1;
        wr(12'h0c8, B5);
        rd(12'h0c8, v); chk("R6 event wins", v, B5);

        // R4/R9 level mode on pin 191 (bank 5 bit 31)
        wr(12'h314, B31);
        rd(12'h0d8, v); chk("R4 inactive high-level", v, 0);
        wr(12'h32c, B31);
        rd(12'h0d8, v); chk("R9 no status on polarity write", v, 0);
        tick();
        rd(12'h0d8, v); chk("R4 active-low sets", v, B31);
        wr(12'h0d8, B31);
        rd(12'h0d8, v); chk("R4 level re-sets after clear", v, B31);
        pins[191] = 1'b1;
        wr(12'h0d8, B31);
        rd(12'h0d8, v); chk("R4 inactive clears", v, 0);
        wr(12'h32c, 32'h0);
        tick();
        rd(12'h0d8, v); chk("R4 active-high sets", v, B31);

        // random phase against the model
        rst = 1'b1; pins = '0; tick(); rst = 1'b0;
        model_reset();
        void'($urandom(32'd1234));
        for (int c = 0; c < RAND_CYC; c++) begin
            logic [11:0] ra;
            int          rk;
            if ($urandom_range(1, 0) == 1) pins[$urandom_range(PW-1, 0)] ^= 1'b1;
            reg_we    = ($urandom_range(2, 0) == 0);
            rk        = $urandom_range(8, 0);
            reg_addr  = (rk == 8) ? 12'($urandom_range(4095, 0))
                                  : 12'(base_of(rk) + 4*$urandom_range(NB-1, 0));
            reg_wdata = $urandom;
            @(posedge clk);
            model_step(pins, reg_we, reg_addr, reg_wdata);
            @(negedge clk);
            reg_we = 1'b0;
            chk("R7 random irq", {31'b0, irq}, {31'b0, exp_irq()});
            chk("R8 random wake_req", {31'b0, wake_req}, {31'b0, exp_wake()});
            rk = $urandom_range(8, 0);
            ra = (rk == 8) ? 12'($urandom_range(4095, 0))
                           : 12'(base_of(rk) + 4*$urandom_range(NB-1, 0));
            rd(ra, v);
            rk = addr_kind(ra);
            chk("R2 random read", v, (rk >= 0) ? m_reg[rk][addr_bank(ra, rk)] : 32'h0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule